// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a per-core watchdog that raises its response one step for every timing period that ends without a service write. After the first missed period it raises an interrupt. After the second it also raises a non-maskable interrupt. After the third it emits a one-cycle soft-reset request. Software configures the block with a single configuration write that sets a 16-bit length, a 2-bit mode and a 2-bit divisor select. It keeps the block quiet by strobing `poke` often enough. The remaining ticks of the current period and the current stage can be read at any time.

The period is made by a prescaler and a down-counter. The prescaler emits one tick every D input clocks, and D is selected from three powers of two. The length field fills the top bits of the down-counter and the low `FRAC_W` bits load as zero. One period is therefore length × 2^FRAC_W ticks. All controls are plain strobes and levels. There is no streamed data, so no valid/ready handshake is used. Every output comes straight from a register.

Top module: `esc_wdog`

## Requirements
- R1: After reset the block is disabled (mode 0). `cnt_val` is 0, `stage` is 0, and `irq`, `nmi` and `srst_req` are low.
- R2: On the clock edge that samples `cfg_wr`, the block latches `cfg_len`, `cfg_mode` and `cfg_div`. It loads `cnt_val` with `cfg_len` shifted left by `FRAC_W` (low bits zero), clears the stage to 0 and restarts the prescaler from zero.
- R3: While enabled, `cnt_val` drops by one every D clocks. D is 2^PRE_LOG2 for `cfg_div`=0, 2^(PRE_LOG2+1) for 1, and 2^(PRE_LOG2+2) for 2 or 3. The first decrement comes D edges after a reload.
- R4: The tick that finds `cnt_val` equal to 1 ends the period. On that tick the counter reloads from the latched length instead of reaching zero, so a period lasts length × 2^FRAC_W × D clocks.
- R5: In mode 3 the ends of successive unserviced periods move the stage 0→1→2. The next period end drives `srst_req` high for exactly one cycle, returns the stage to 0 and reloads the counter.
- R6: In mode 1 the stage stops at 1, and in mode 2 it stops at 2. In these modes the last stage holds through further period ends and `srst_req` never rises.
- R7: When the block is enabled, `poke` reloads the counter, restarts the prescaler, sets the stage to 0 and drops `irq` and `nmi`. A poke on the same edge as a period end wins, so no escalation happens.
- R8: Mode 0 disables the block. The counter holds its value, the stage stays 0, all outputs stay low and `poke` has no effect. Writing mode 0 while escalated drops the outputs at once.
- R9: `irq` is high whenever the stage is 1 or 2. It therefore rises exactly once per escalation and is already high when `nmi` rises.
- R10: The stage encoding is 0 = idle, 1 = interrupt, 2 = NMI. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length (upper counter bits) |
| cfg_mode | input | 2 | 0 off, 1 irq only, 2 up to NMI, 3 up to soft reset |
| cfg_div | input | 2 | Prescaler divisor select |
| poke | input | 1 | Service strobe |
| cnt_val | output | LEN_W+FRAC_W | Ticks left in the current period |
| stage | output | 2 | Current escalation stage |
| irq | output | 1 | Interrupt level |
| nmi | output | 1 | Non-maskable interrupt level |
| srst_req | output | 1 | One-cycle soft-reset request |

## Verification
The bench builds the block with `FRAC_W`=2 and `PRE_LOG2`=2, so the divisors are 4, 8 and 16 and a length of 3 gives a 48-clock period. At these values a full three-period escalation to the reset pulse takes a few hundred clocks. That makes it possible to check every mode's hold behaviour, all four divisor codes, and a poke that lands on the exact expiry edge, all against a cycle-exact reference model. The defaults (8 and 8) only lengthen the period and leave the sequencing unchanged.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2
  } wd_stage_e;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_IRQ = 2'd1,
    MODE_NMI = 2'd2,
    MODE_RST = 2'd3
  } wd_mode_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int BASE_LOG2 = 8,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NDIV = 3;
  localparam int PW   = BASE_LOG2 + NDIV - 1;

  logic [PW-1:0] lim [NDIV];
  logic [PW-1:0] limit;
  logic [PW-1:0] pcnt;

  for (genvar i = 0; i < NDIV; i++) begin : g_lim
    assign lim[i] = PW'((64'd1 << (BASE_LOG2 + i)) - 64'd1);
  end

  always_comb begin
    case (sel)
      SEL_W'(0): limit = lim[0];
      SEL_W'(1): limit = lim[1];
      default:   limit = lim[2];
    endcase
  end

  assign tick = run && !restart && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pcnt <= '0;
    else if (restart || !run)    pcnt <= '0;
    else if (tick)               pcnt <= '0;
    else                         pcnt <= pcnt + PW'(1);
  end

  // R3
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pcnt <= limit);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int LEN_W  = 16,
  parameter int FRAC_W = 8,
  localparam int CW    = LEN_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             tick,
  output logic [CW-1:0]    cnt,
  output logic             expire
);
  logic [CW-1:0] reload_val;

  assign reload_val = {load_len, {FRAC_W{1'b0}}};
  assign expire     = tick && (cnt <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load || expire)   cnt <= reload_val;
    else if (tick)             cnt <= cnt - CW'(1);
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !expire && !load) |=> cnt == $past(cnt) - CW'(1));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       expire,
  input  logic [1:0] mode,
  output logic [1:0] stage,
  output logic       irq,
  output logic       nmi,
  output logic       srst
);
  wd_stage_e stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      srst    <= 1'b0;
    end else if (clear) begin
      stage_q <= ST_IDLE;
      srst    <= 1'b0;
    end else begin
      srst <= 1'b0;
      if (expire && (stage_q < mode)) begin
        if (stage_q == ST_NMI) begin
          srst    <= 1'b1;
          stage_q <= ST_IDLE;
        end else begin
          stage_q <= wd_stage_e'(stage_q + 2'd1);
        end
      end
    end
  end

  assign stage = stage_q;
  assign irq   = (stage_q != ST_IDLE);
  assign nmi   = (stage_q == ST_NMI);

  // R5
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);

  // R5
  srst_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> $past(stage_q) == ST_NMI);

  // R6
  srst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> mode == MODE_RST);

  // R9
  irq_before_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(irq));

  // R10
  stage_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q != 2'd3);

endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import wdog_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int FRAC_W   = 8,
  parameter int PRE_LOG2 = 8,
  localparam int CW      = LEN_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_div,
  input  logic             poke,
  output logic [CW-1:0]    cnt_val,
  output logic [1:0]       stage,
  output logic             irq,
  output logic             nmi,
  output logic             srst_req
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic [1:0]       div_q;
  logic             enabled;
  logic             load;
  logic             tick;
  logic             expire;
  logic [LEN_W-1:0] load_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= MODE_OFF;
      div_q  <= '0;
    end else if (cfg_wr) begin
      len_q  <= cfg_len;
      mode_q <= cfg_mode;
      div_q  <= cfg_div;
    end
  end

  assign enabled  = (mode_q != MODE_OFF);
  assign load     = cfg_wr || (poke && enabled);
  assign load_len = cfg_wr ? cfg_len : len_q;

  wdog_prescale #(.BASE_LOG2(PRE_LOG2), .SEL_W(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enabled), .restart(load),
    .sel(div_q), .tick(tick)
  );

  wdog_count #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_len(load_len),
    .tick(tick), .cnt(cnt_val), .expire(expire)
  );

  wdog_stage u_stg (
    .clk(clk), .rst_n(rst_n), .clear(load), .expire(expire),
    .mode(mode_q), .stage(stage), .irq(irq), .nmi(nmi), .srst(srst_req)
  );

  // R7
  poke_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poke && enabled) |=> (stage == ST_IDLE) && !irq && !nmi && !srst_req);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cnt_val == (CW'($past(cfg_len)) << FRAC_W));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !irq && !nmi && !srst_req);

endmodule

// File: tb/esc_wdog_test.sv
module esc_wdog_test;
  localparam int LW = 16;
  localparam int FW = 2;
  localparam int PL = 2;
  localparam int CW = LW + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [1:0]    cfg_mode = '0;
  logic [1:0]    cfg_div = '0;
  logic          poke = 1'b0;
  logic [CW-1:0] cnt_val;
  logic [1:0]    stage;
  logic          irq, nmi, srst_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int srst_seen = 0;
  bit done = 1'b0;

  esc_wdog #(.LEN_W(LW), .FRAC_W(FW), .PRE_LOG2(PL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .cfg_div(cfg_div), .poke(poke),
    .cnt_val(cnt_val), .stage(stage), .irq(irq), .nmi(nmi),
    .srst_req(srst_req)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Behavioural reference: elapsed clocks since the last reload.
  int m_mode, m_len, m_sel, m_cyc, m_stage;
  bit m_srst;

  function automatic int m_div();
    return (m_sel >= 2) ? (1 << (PL + 2)) : (1 << (PL + m_sel));
  endfunction

  function automatic int m_base();
    return m_len * (1 << FW);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_len = 0; m_sel = 0; m_cyc = 0; m_stage = 0; m_srst = 0;
    end else begin
      m_srst = 0;
      if (cfg_wr) begin
        m_mode = cfg_mode; m_len = cfg_len; m_sel = cfg_div;
        m_cyc = 0; m_stage = 0;
      end else if (poke && m_mode != 0) begin
        m_cyc = 0; m_stage = 0;
      end else if (m_mode != 0) begin
        m_cyc++;
        if (m_cyc == m_base() * m_div()) begin
          m_cyc = 0;
          if (m_stage < m_mode) begin
            if (m_stage == 2) begin m_srst = 1; m_stage = 0; end
            else m_stage++;
          end
        end
      end
      if (srst_req) srst_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(int'(cnt_val) == m_base() - m_cyc / m_div(), "R4 cnt", int'(cnt_val),
          m_base() - m_cyc / m_div());
      chk(int'(stage) == m_stage, "R5 stage", int'(stage), m_stage);
      chk(irq == (m_stage != 0), "R9 irq", int'(irq), int'(m_stage != 0));
      chk(nmi == (m_stage == 2), "R5 nmi", int'(nmi), int'(m_stage == 2));
      chk(srst_req == m_srst, "R5 srst", int'(srst_req), int'(m_srst));
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input int len, input int mode, input int sel);
    cfg_len = LW'(len); cfg_mode = 2'(mode); cfg_div = 2'(sel); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_poke();
    poke = 1'b1;
    @(negedge clk);
    poke = 1'b0;
  endtask

  initial begin
    int s0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(cnt_val == 0 && stage == 0, "R1 cnt/stage", int'(cnt_val), 0);
    chk(!irq && !nmi && !srst_req, "R1 outputs", int'({irq, nmi, srst_req}), 0);

    // Full escalation: length 3 -> 12 ticks, D=4, period 48 clocks
    wr_cfg(3, 3, 0);
    chk(cnt_val == 12, "R2 load", int'(cnt_val), 12);
    step(4);
    chk(cnt_val == 11, "R3 first tick", int'(cnt_val), 11);
    step(43);
    chk(!irq, "R5 irq early", int'(irq), 0);
    step(1);
    chk(irq && stage == 1, "R10 stage1", int'(stage), 1);
    step(48);
    chk(nmi && irq, "R9 nmi with irq", int'({irq, nmi}), 3);
    step(47);
    chk(!srst_req, "R5 srst early", int'(srst_req), 0);
    step(1);
    chk(srst_req && stage == 0 && !irq, "R5 srst pulse", int'(srst_req), 1);
    step(1);
    chk(!srst_req && cnt_val == 12, "R4 reload after reset", int'(cnt_val), 12);

    // Poke during stage 1
    wr_cfg(2, 3, 0);
    step(32);
    chk(irq, "R7 pre-poke irq", int'(irq), 1);
    do_poke();
    chk(!irq && stage == 0 && cnt_val == 8, "R7 poke clears", int'(cnt_val), 8);

    // Poke on the expiry edge
    wr_cfg(2, 3, 0);
    step(31);
    do_poke();
    chk(!irq && stage == 0, "R7 poke wins", int'(stage), 0);

    // Mode 1 holds at stage 1
    s0 = srst_seen;
    wr_cfg(1, 1, 0);
    step(64);
    chk(stage == 1 && irq && !nmi, "R6 mode1 hold", int'(stage), 1);
    // Mode 2 holds at stage 2
    wr_cfg(1, 2, 0);
    step(80);
    chk(stage == 2 && nmi, "R6 mode2 hold", int'(stage), 2);
    chk(srst_seen == s0, "R6 no reset", srst_seen, s0);

    // Divisor selects
    wr_cfg(2, 3, 1);
    step(8);
    chk(cnt_val == 7, "R3 div8", int'(cnt_val), 7);
    wr_cfg(2, 3, 2);
    step(15);
    chk(cnt_val == 8, "R3 div16 before", int'(cnt_val), 8);
    step(1);
    chk(cnt_val == 7, "R3 div16", int'(cnt_val), 7);
    wr_cfg(2, 3, 3);
    step(16);
    chk(cnt_val == 7, "R3 sel3", int'(cnt_val), 7);

    // Disabled
    wr_cfg(5, 0, 0);
    step(200);
    chk(cnt_val == 20 && stage == 0 && !irq, "R8 frozen", int'(cnt_val), 20);
    do_poke();
    step(2);
    chk(cnt_val == 20 && !irq && !nmi, "R8 poke ignored", int'(cnt_val), 20);
    wr_cfg(1, 3, 0);
    step(16);
    chk(irq, "R8 pre-disable irq", int'(irq), 1);
    wr_cfg(0, 0, 0);
    chk(!irq && cnt_val == 0 && stage == 0, "R8 disable drops", int'(irq), 0);
    step(5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule